// File: doc/BRIEF.md
# Game I/O Soft-Switch Controller

This block sits on an 8-bit processor bus and turns bus accesses into game-port actions. Decoding uses only the address. Whether the access is a read or a write makes no difference, with two exceptions: read data is produced only for reads, and the strobe pulse count depends on the direction.

- **Lamps.** Touching one of eight consecutive addresses sets or clears one of four lamp outputs. These are static control levels.
- **Status bytes.** Reading a small status window returns a byte whose top bit is either the level of one of three pushbuttons or the running state of one of four paddle timers.
- **Paddle timers.** Touching any address in a sixteen-byte window restarts all four paddle timers together. Each timer stays high for a time proportional to a digital setting that stands in for a resistance.
- **Strobe.** A dedicated address produces an active-low strobe pulse.

An access is recognised once, on the rising edge of the phase-0 qualifier as seen by the system clock. Holding phase 0 high for many cycles therefore counts as one access.

Top module: `gameio_ctrl`

## Requirements
- R1: In the cycle after synchronous reset is released, `lamp` is 0, `strobe_n` is 1, `rdata` is 0, and every paddle timer reads back as idle (bit 7 = 0).
- R2: An access (read or write) to address 16'hC058 + 2k clears `lamp[k]`, and an access to 16'hC059 + 2k sets it, for k = 0..3. The new value appears one clock after the access edge.
- R3: `lamp` keeps its value through accesses to every address outside 16'hC058–16'hC05F and through cycles with no access.
- R4: A read of 16'hC061, 16'hC062 or 16'hC063 returns `btn[0]`, `btn[1]` or `btn[2]` respectively in bit 7 (1 = pressed), with bits 6:0 equal to 0.
- R5: A read of 16'hC064 + j (j = 0..3) returns 1 in bit 7 while paddle timer j is running and 0 when it is idle, with bits 6:0 equal to 0.
- R6: An access to any address in 16'hC070–16'hC07F restarts all four paddle timers at once. Each timer latches its own field of `pdl_set` (channel j in bits [j*PDL_W +: PDL_W]) at that moment.
- R7: After a restart, timer j stays running for exactly (setting_j + 1) × TICK_CYC clock cycles, counted from the clock edge that recognises the access.
- R8: A read access to 16'hC040 drives `strobe_n` low for exactly STB_CYC cycles, starting one clock after the access edge, and then returns it high.
- R9: A write access to 16'hC040 produces two low pulses of STB_CYC cycles each, separated by STB_CYC high cycles.
- R10: An access is recognised only on a low-to-high transition of `ph0`. Keeping `ph0` high while the address changes triggers nothing further.
- R11: `rdata` is updated only by read accesses. A read of any address outside 16'hC061–16'hC067 returns 8'h00, and write accesses leave `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Bus address |
| rw | input | 1 | 1 = read access, 0 = write access |
| ph0 | input | 1 | Phase-0 qualifier; its rising edge marks one access |
| btn | input | 3 | Pushbutton levels, 1 = pressed |
| pdl_set | input | 4*PDL_W | Per-channel paddle setting, channel j in bits [j*PDL_W +: PDL_W] |
| rdata | output | 8 | Registered status byte from the last read access |
| lamp | output | 4 | Static lamp outputs |
| strobe_n | output | 1 | Active-low strobe pulse |

## Verification
A wrong access detector shows up as lamp or strobe changes on the cycle after a held `ph0`, or as a missing change one clock after a fresh rising edge.

A wrong paddle count or prescaler appears only at the timer's end. For that reason the bench reads the status bit on the last running cycle and again on the first idle cycle, which shows any off-by-one.

A strobe sequencer stuck in its gap or second-pulse state shows up within 2×STB_CYC cycles as a low level where the idle level is due. A wrong decode or read mux shows up as the wrong bit 7 in the very next `rdata`.

// File: rtl/gameio_pkg.sv
package gameio_pkg;
  localparam int LAMP_N = 4;
  localparam int BTN_N  = 3;
  localparam int PDL_N  = 4;
  localparam int STAT_N = BTN_N + PDL_N;

  localparam logic [15:0] A_LAMP_BASE = 16'hC058;
  localparam logic [15:0] A_STROBE    = 16'hC040;
  localparam logic [15:0] A_STAT_BASE = 16'hC060;
  localparam logic [15:0] A_PDL_RST   = 16'hC070;

  typedef struct packed {
    logic       acc;
    logic       rd;
    logic       wr;
    logic       lamp_hit;
    logic [1:0] lamp_idx;
    logic       lamp_val;
    logic       stb_hit;
    logic       pdl_rst;
    logic       stat_hit;
    logic [2:0] stat_sel;
  } dec_t;
endpackage

// File: rtl/gameio_decode.sv
module gameio_decode
  import gameio_pkg::*;
(
  input  logic        clk,
  input  logic [15:0] addr,
  input  logic        rw,
  input  logic        ph0,
  output dec_t        dec
);
  logic ph0_q;

  always_ff @(posedge clk) ph0_q <= ph0;

  always_comb begin
    dec          = '0;
    dec.acc      = ph0 & ~ph0_q;
    dec.rd       = dec.acc & rw;
    dec.wr       = dec.acc & ~rw;
    dec.lamp_hit = dec.acc & (addr[15:3] == A_LAMP_BASE[15:3]);
    dec.lamp_idx = addr[2:1];
    dec.lamp_val = addr[0];
    dec.stb_hit  = dec.acc & (addr == A_STROBE);
    dec.pdl_rst  = dec.acc & (addr[15:4] == A_PDL_RST[15:4]);
    dec.stat_hit = (addr[15:3] == A_STAT_BASE[15:3]) & (addr[2:0] != 3'd0);
    dec.stat_sel = addr[2:0] - 3'd1;
  end
endmodule

// File: rtl/gameio_strobe.sv
module gameio_strobe #(
  parameter int STB_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic twice,
  output logic strobe_n
);
  localparam int CW = (STB_CYC > 1) ? $clog2(STB_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(STB_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_GAP} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic          more;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      more     <= 1'b0;
      strobe_n <= 1'b1;
    end else if (fire) begin
      st       <= S_LOW;
      cnt      <= LOAD;
      more     <= twice;
      strobe_n <= 1'b0;
    end else begin
      case (st)
        S_LOW: begin
          if (cnt == '0) begin
            strobe_n <= 1'b1;
            cnt      <= LOAD;
            st       <= more ? S_GAP : S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_GAP: begin
          if (cnt == '0) begin
            strobe_n <= 1'b0;
            cnt      <= LOAD;
            more     <= 1'b0;
            st       <= S_LOW;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          strobe_n <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/gameio_paddle.sv
module gameio_paddle #(
  parameter int PDL_W    = 8,
  parameter int TICK_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [PDL_W-1:0] setting,
  output logic             running
);
  localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [PW-1:0] PRE_LOAD = PW'(TICK_CYC - 1);

  logic [PDL_W-1:0] cnt;
  logic [PW-1:0]    pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      pre     <= '0;
    end else if (restart) begin
      running <= 1'b1;
      cnt     <= setting;
      pre     <= PRE_LOAD;
    end else if (running) begin
      if (pre == '0) begin
        pre <= PRE_LOAD;
        if (cnt == '0) running <= 1'b0;
        else           cnt     <= cnt - 1'b1;
      end else begin
        pre <= pre - 1'b1;
      end
    end
  end
endmodule

// File: rtl/gameio_ctrl.sv
module gameio_ctrl
  import gameio_pkg::*;
#(
  parameter int STB_CYC  = 2,
  parameter int PDL_W    = 8,
  parameter int TICK_CYC = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [15:0]              addr,
  input  logic                     rw,
  input  logic                     ph0,
  input  logic [BTN_N-1:0]         btn,
  input  logic [PDL_N*PDL_W-1:0]   pdl_set,
  output logic [7:0]               rdata,
  output logic [LAMP_N-1:0]        lamp,
  output logic                     strobe_n
);
  dec_t             dec;
  logic [PDL_N-1:0] pdl_run;
  logic [STAT_N-1:0] stat;
  logic             stat_bit;

  gameio_decode u_dec (
    .clk (clk),
    .addr(addr),
    .rw  (rw),
    .ph0 (ph0),
    .dec (dec)
  );

  gameio_strobe #(.STB_CYC(STB_CYC)) u_stb (
    .clk     (clk),
    .rst     (rst),
    .fire    (dec.stb_hit),
    .twice   (dec.wr),
    .strobe_n(strobe_n)
  );

  for (genvar j = 0; j < PDL_N; j++) begin : g_pdl
    gameio_paddle #(.PDL_W(PDL_W), .TICK_CYC(TICK_CYC)) u_pdl (
      .clk    (clk),
      .rst    (rst),
      .restart(dec.pdl_rst),
      .setting(pdl_set[j*PDL_W +: PDL_W]),
      .running(pdl_run[j])
    );
  end

  assign stat     = {pdl_run, btn};
  assign stat_bit = dec.stat_hit & stat[dec.stat_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      lamp  <= '0;
      rdata <= '0;
    end else begin
      if (dec.lamp_hit) lamp[dec.lamp_idx] <= dec.lamp_val;
      if (dec.rd)       rdata <= {stat_bit, 7'd0};
    end
  end
endmodule

// File: rtl/gameio_ctrl_chk.sv
module gameio_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] addr,
  input logic        rw,
  input logic        ph0,
  input logic [2:0]  btn,
  input logic [7:0]  rdata,
  input logic [3:0]  lamp,
  input logic        strobe_n
);
  logic ph0_d;
  logic acc_c;

  always_ff @(posedge clk) ph0_d <= ph0;
  assign acc_c = ph0 & ~ph0_d;

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lamp == 4'd0 && strobe_n && rdata == 8'd0)); // R1

  AST_LAMP_SET0: assert property (@(posedge clk) disable iff (rst)
    (acc_c && addr == 16'hC059) |=> lamp[0]); // R2

  AST_LAMP_CLR3: assert property (@(posedge clk) disable iff (rst)
    (acc_c && addr == 16'hC05E) |=> !lamp[3]); // R2

  AST_LAMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(acc_c && addr[15:3] == 13'h180B) |=> $stable(lamp)); // R3

  AST_BTN0_READ: assert property (@(posedge clk) disable iff (rst)
    (acc_c && rw && addr == 16'hC061) |=> (rdata == {$past(btn[0]), 7'd0})); // R4

  AST_STROBE_START: assert property (@(posedge clk) disable iff (rst)
    (acc_c && addr == 16'hC040) |=> !strobe_n); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(acc_c && rw) |=> $stable(rdata)); // R11
endmodule

bind gameio_ctrl gameio_ctrl_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .rw      (rw),
  .ph0     (ph0),
  .btn     (btn),
  .rdata   (rdata),
  .lamp    (lamp),
  .strobe_n(strobe_n)
);

// File: tb/tb_gameio_ctrl.sv
module tb_gameio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int STB_CYC    = 2;
  localparam int PDL_W      = 8;
  localparam int TICK_CYC   = 4;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [15:0]          addr = 16'h0000;
  logic                 rw = 1'b1;
  logic                 ph0 = 1'b0;
  logic [2:0]           btn = 3'b000;
  logic [4*PDL_W-1:0]   pdl_set = '0;
  logic [7:0]           rdata;
  logic [3:0]           lamp;
  logic                 strobe_n;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gameio_ctrl #(.STB_CYC(STB_CYC), .PDL_W(PDL_W), .TICK_CYC(TICK_CYC)) dut (
    .clk(clk), .rst(rst), .addr(addr), .rw(rw), .ph0(ph0), .btn(btn),
    .pdl_set(pdl_set), .rdata(rdata), .lamp(lamp), .strobe_n(strobe_n)
  );

  // {addr, rw, btn, exp_rdata, exp_lamp}
  localparam int NV = 17;
  localparam logic [31:0] VEC [NV] = '{
    {16'hC059, 1'b0, 3'b000, 8'h00, 4'b0001},  // R2 set 0 by write
    {16'hC05B, 1'b1, 3'b000, 8'h00, 4'b0011},  // R2 set 1 by read
    {16'hC05D, 1'b0, 3'b000, 8'h00, 4'b0111},  // R2
    {16'hC05F, 1'b1, 3'b000, 8'h00, 4'b1111},  // R2
    {16'hC05A, 1'b0, 3'b000, 8'h00, 4'b1101},  // R2 clear 1
    {16'hC061, 1'b1, 3'b001, 8'h80, 4'b1101},  // R4 btn0
    {16'hC062, 1'b1, 3'b001, 8'h00, 4'b1101},  // R4 btn1 released
    {16'hC063, 1'b1, 3'b100, 8'h80, 4'b1101},  // R4 btn2
    {16'hC062, 1'b0, 3'b010, 8'h80, 4'b1101},  // R11 write keeps rdata
    {16'hC062, 1'b1, 3'b010, 8'h80, 4'b1101},  // R4
    {16'hC061, 1'b1, 3'b110, 8'h00, 4'b1101},  // R4
    {16'hC050, 1'b1, 3'b111, 8'h00, 4'b1101},  // R3 R11 other address
    {16'hC058, 1'b1, 3'b000, 8'h00, 4'b1100},  // R2 clear 0
    {16'hC064, 1'b1, 3'b000, 8'h00, 4'b1100},  // R5 paddle idle
    {16'hC05E, 1'b0, 3'b000, 8'h00, 4'b0100},  // R2 clear 3
    {16'hC060, 1'b1, 3'b111, 8'h00, 4'b0100},  // R11 unassigned status
    {16'hC05C, 1'b0, 3'b000, 8'h00, 4'b0000}   // R2 clear 2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus access: ph0 rises at a negedge, held one cycle, then dropped
  task automatic access(input logic [15:0] a, input logic r);
    @(negedge clk);
    addr = a; rw = r; ph0 = 1'b1;
    @(negedge clk);
    ph0 = 1'b0;
  endtask

  task automatic strobe_pattern(input logic r, input logic [7:0] exp, input string req);
    logic [7:0] got;
    @(negedge clk);
    addr = 16'hC040; rw = r; ph0 = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      ph0 = 1'b0;
      got[i] = strobe_n;
    end
    check(req, {24'd0, got}, {24'd0, exp});
  endtask

  // restart timers, wait dly negedges after the access, then read channel ch
  task automatic probe(input int ch, input int dly, input logic exp, input string req);
    access(16'hC070, 1'b0);
    repeat (dly - 1) @(negedge clk);
    access(16'hC064 + 16'(ch), 1'b1);
    check(req, {31'd0, rdata[7]}, {31'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 lamp", {28'd0, lamp}, 32'd0);
    check("R1 strobe_n", {31'd0, strobe_n}, 32'd1);
    check("R1 rdata", {24'd0, rdata}, 32'd0);
    access(16'hC067, 1'b1);
    check("R1 paddle idle", {24'd0, rdata}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      btn = VEC[i][14:12];
      access(VEC[i][31:16], VEC[i][15]);
      check($sformatf("R2/R3/R4/R11 vec%0d rdata", i), {24'd0, rdata}, {24'd0, VEC[i][11:4]});
      check($sformatf("R2/R3 vec%0d lamp", i), {28'd0, lamp}, {28'd0, VEC[i][3:0]});
    end

    // R10: ph0 held high while address moves to another lamp address
    @(negedge clk);
    addr = 16'hC059; rw = 1'b0; ph0 = 1'b1;
    @(negedge clk);
    addr = 16'hC05B;
    repeat (3) @(negedge clk);
    check("R10 held ph0", {28'd0, lamp}, 32'b0001);
    ph0 = 1'b0;
    @(negedge clk);
    check("R10 no access", {28'd0, lamp}, 32'b0001);

    // R8 / R9 strobe shapes (STB_CYC = 2)
    strobe_pattern(1'b1, 8'b0011_1111, "R8 read strobe");
    strobe_pattern(1'b0, 8'b0011_0011, "R9 write strobe");

    // R6 / R7 paddle durations: setting 3 -> 16 cycles, setting 9 -> 40 cycles
    pdl_set = {8'd9, 8'd0, 8'd5, 8'd3};
    probe(0, 15, 1'b1, "R7 ch0 last running");
    probe(0, 16, 1'b0, "R7 ch0 first idle");
    probe(3, 39, 1'b1, "R6 R7 ch3 last running");
    probe(3, 40, 1'b0, "R7 ch3 first idle");
    probe(2, 3, 1'b1, "R5 ch2 setting 0 running");
    probe(2, 4, 1'b0, "R5 ch2 setting 0 idle");
    // R6: setting latched at restart; a later change does not stretch it
    access(16'hC07F, 1'b1);
    pdl_set = {8'd9, 8'd0, 8'd5, 8'd200};
    repeat (15) @(negedge clk);
    access(16'hC064, 1'b1);
    check("R6 latched setting", {24'd0, rdata}, 32'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule